// File: doc/BRIEF.md
# Four-Level Address Strap Classifier

This block works out which of four connections each of two address strap pins has: ground, supply, the serial data line or the serial clock line. It turns the two results into the low four bits of a serial-bus slave address. It also produces one pullup enable for each group of four ports and an eight-bit vector of power-up port levels. The strap, data and clock levels reach the block already synchronized to `clk_i`. A bus-condition detector elsewhere in the design provides single-cycle START and STOP strobes.

A strap tied to a bus line cannot be told from a fixed level while the bus is idle, because both lines sit high then. The block therefore watches every transmission on the bus, whichever device it is addressed to. During the frame it records whether each strap ever disagreed with the data line and whether it ever disagreed with the clock line. At STOP it commits a new class for each strap. Before the first commit, each strap is classed from its live idle level, so a strap tied to a bus line reads as supply. The address used during a frame is always the one committed before that frame began.

Top module: `addr_pin_classifier`

## Requirements
- R1: While reset is held, `addr_valid_o` is 0 and both classes are ground (`addr_lo_o` = 0000). After reset, `addr_valid_o` stays 0 until the first STOP that ends a frame.
- R2: Before the first commit and outside a frame, each class follows the live strap level one cycle later: low gives 00 and high gives 01. A strap tied to a bus line that idles high therefore reads 01.
- R3: A strap that equals the data level on every sampled cycle of a frame, and differs from the clock level at least once, is committed as 10.
- R4: A strap that equals the clock level on every sampled cycle of a frame, and differs from the data level at least once, is committed as 11.
- R5: Any other strap is committed as {0, level at the STOP cycle}: ground gives 00 and supply gives 01. This includes a strap that disagrees with both lines and a strap that never disagrees with either.
- R6: `addr_lo_o` = {AD2 class, AD0 class}. `pu_lo_o` is 1 when the AD0 class is not 00, and `pu_hi_o` is 1 when the AD2 class is not 00. `port_default_o[3:0]` repeats `pu_lo_o` and `port_default_o[7:4]` repeats `pu_hi_o`.
- R7: During a frame, `addr_lo_o` holds the value committed before that frame's START. It changes only on the clock edge that samples STOP.
- R8: A STOP strobe outside a frame has no effect.
- R9: A START inside a frame (repeated start) does not clear the disagreement history. Classification covers the whole frame up to STOP.
- R10: `addr_valid_o` rises on the edge that samples the first in-frame STOP and then stays 1 until reset.
- R11: All 16 pairs of strap connections give distinct addresses, equal to {AD2 code, AD0 code}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ad0_i | input | 1 | Synchronized level of the strap for ports 3..0 |
| ad2_i | input | 1 | Synchronized level of the strap for ports 7..4 |
| sda_i | input | 1 | Synchronized data line level |
| scl_i | input | 1 | Synchronized clock line level |
| start_i | input | 1 | One-cycle START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| addr_lo_o | output | 4 | Low slave address bits {AD2 class, AD0 class} |
| addr_valid_o | output | 1 | A bus-observed classification has been committed |
| pu_lo_o | output | 1 | Pullup enable for ports 3..0 |
| pu_hi_o | output | 1 | Pullup enable for ports 7..4 |
| port_default_o | output | 8 | Power-up port levels |

## Verification
A stuck or misset disagreement flag shows up at the ports only at the next STOP. It then appears as a wrong two-bit class in `addr_lo_o` and as a wrong pullup and default nibble, and it stays until the following frame ends. A frame-tracking error shows up sooner, as an address that moves in the middle of a frame or a STOP that commits without a frame. Because of this, each classification case is checked on the cycle right after its STOP, and the outputs are also sampled during frames.

// File: rtl/addr_pin_classifier.sv
module addr_pin_classifier #(
  parameter int PORTS_PER_STRAP = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ad0_i,
  input  logic                         ad2_i,
  input  logic                         sda_i,
  input  logic                         scl_i,
  input  logic                         start_i,
  input  logic                         stop_i,
  output logic [3:0]                   addr_lo_o,
  output logic                         addr_valid_o,
  output logic                         pu_lo_o,
  output logic                         pu_hi_o,
  output logic [2*PORTS_PER_STRAP-1:0] port_default_o
);
  localparam int NSTRAP = 2;
  localparam logic [1:0] CLS_GND = 2'b00;
  localparam logic [1:0] CLS_SDA = 2'b10;
  localparam logic [1:0] CLS_SCL = 2'b11;

  logic              in_frame_q;
  logic              committed_q;
  logic [NSTRAP-1:0] strap;
  logic [1:0]        cls [NSTRAP];

  assign strap = {ad2_i, ad0_i};

  wire frame_open = start_i && !in_frame_q;
  wire frame_end  = stop_i && in_frame_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      in_frame_q  <= 1'b0;
      committed_q <= 1'b0;
    end else begin
      if (frame_open)     in_frame_q <= 1'b1;
      else if (frame_end) in_frame_q <= 1'b0;
      if (frame_end) committed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NSTRAP; g++) begin : g_strap
    logic       sda_diff_q, scl_diff_q;
    logic [1:0] cls_q;
    wire sda_diff_n = sda_diff_q | (strap[g] ^ sda_i);
    wire scl_diff_n = scl_diff_q | (strap[g] ^ scl_i);
    logic [1:0] verdict;

    always_comb begin
      if (!sda_diff_n && scl_diff_n)      verdict = CLS_SDA;
      else if (sda_diff_n && !scl_diff_n) verdict = CLS_SCL;
      else                                verdict = {1'b0, strap[g]};
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        sda_diff_q <= 1'b0;
        scl_diff_q <= 1'b0;
        cls_q      <= CLS_GND;
      end else if (frame_open) begin
        sda_diff_q <= 1'b0;
        scl_diff_q <= 1'b0;
      end else if (in_frame_q) begin
        sda_diff_q <= sda_diff_n;
        scl_diff_q <= scl_diff_n;
        if (stop_i) cls_q <= verdict;
      end else if (!committed_q) begin
        cls_q <= {1'b0, strap[g]};
      end
    end

    assign cls[g] = cls_q;
  end

  assign addr_lo_o      = {cls[1], cls[0]};
  assign addr_valid_o   = committed_q;
  assign pu_lo_o        = cls[0] != CLS_GND;
  assign pu_hi_o        = cls[1] != CLS_GND;
  assign port_default_o = {{PORTS_PER_STRAP{pu_hi_o}}, {PORTS_PER_STRAP{pu_lo_o}}};

  a_r7_hold_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && !stop_i) |=> $stable(addr_lo_o))
    else $error("R7 address moved inside a frame");

  a_r8_idle_stop_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (committed_q && !in_frame_q && !start_i) |=> $stable(addr_lo_o))
    else $error("R8 address moved while idle after commit");

  a_r10_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> addr_valid_o)
    else $error("R10 valid dropped");

  a_r10_valid_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_valid_o) |-> $past(stop_i))
    else $error("R10 valid rose without stop");

  a_r6_pullup_nibbles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_lo_o == (addr_lo_o[1:0] != 2'b00)) && (pu_hi_o == (addr_lo_o[3:2] != 2'b00)))
    else $error("R6 pullup does not match class");
endmodule

// File: tb/tb_addr_pin_classifier.sv
module tb_addr_pin_classifier;
  logic clk = 0;
  logic rst_n = 0;
  logic sda = 1, scl = 1, start = 0, stop = 0;
  logic [1:0] conn0 = 2'd1, conn2 = 2'd0;
  logic ovr0 = 0, ov_val = 0;
  logic ad0, ad2;
  logic [3:0] addr;
  logic valid, pu_lo, pu_hi;
  logic [7:0] pdef;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  function automatic logic pinv(input logic [1:0] c, input logic d, input logic k);
    case (c)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return d;
      default: return k;
    endcase
  endfunction

  assign ad0 = ovr0 ? ov_val : pinv(conn0, sda, scl);
  assign ad2 = pinv(conn2, sda, scl);

  addr_pin_classifier dut (
    .clk_i(clk), .rst_ni(rst_n), .ad0_i(ad0), .ad2_i(ad2), .sda_i(sda), .scl_i(scl),
    .start_i(start), .stop_i(stop), .addr_lo_o(addr), .addr_valid_o(valid),
    .pu_lo_o(pu_lo), .pu_hi_o(pu_hi), .port_default_o(pdef));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic d, input logic k, input logic st, input logic sp);
    @(negedge clk);
    sda = d; scl = k; start = st; stop = sp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0);
  endtask

  task automatic frame(input logic [1:0] c2, input logic [1:0] c0, input logic [3:0] held);
    @(negedge clk); conn0 = c0; conn2 = c2;
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 1, 0, 0); cyc(0, 1, 0, 0);
    @(negedge clk);
    chk("R7 mid-frame hold", addr, held);
    sda = 1; scl = 1; stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; conn0 = 2'd1; conn2 = 2'd0;
    repeat (2) @(negedge clk);
    chk("R1 reset valid", valid, 0);
    chk("R1 reset addr", addr, 4'b0000);
    rst_n = 1;
    idle(2);
    chk("R1 valid low before commit", valid, 0);
    chk("R2 live idle level", addr, 4'b0001);
    chk("R6 defaults pre-commit", pdef, 8'h0F);
  endtask

  task automatic t_live_bus_tied;
    conn0 = 2'd3; conn2 = 2'd2;
    idle(2);
    chk("R2 bus-tied straps read supply", addr, 4'b0101);
    chk("R6 both pullups", {pu_hi, pu_lo}, 2'b11);
  endtask

  task automatic t_first_frame;
    frame(2'd2, 2'd3, 4'b0101);
    chk("R10 valid after first stop", valid, 1);
    chk("R3 SDA on AD2 / R4 SCL on AD0", addr, 4'b1011);
    chk("R6 defaults bus-tied", pdef, 8'hFF);
  endtask

  task automatic t_fixed;
    frame(2'd0, 2'd1, 4'b1011);
    chk("R5 ground/supply", addr, 4'b0001);
    chk("R6 default vector", pdef, 8'h0F);
    chk("R6 pullups", {pu_hi, pu_lo}, 2'b01);
    frame(2'd1, 2'd0, 4'b0001);
    chk("R5 supply/ground", addr, 4'b0100);
    chk("R6 default vector hi", pdef, 8'hF0);
  endtask

  task automatic t_stray_stop;
    conn0 = 2'd2; conn2 = 2'd3;
    cyc(0, 1, 0, 1);
    cyc(1, 0, 0, 0);
    idle(2);
    chk("R8 stray stop ignored", addr, 4'b0100);
    chk("R8 valid kept", valid, 1);
  endtask

  task automatic t_both_diff;
    @(negedge clk); conn2 = 2'd0; ovr0 = 1; ov_val = 1;
    cyc(0, 1, 1, 0); ov_val = 1;
    cyc(0, 0, 0, 0); ov_val = 1;
    cyc(1, 1, 0, 0); ov_val = 0;
    cyc(1, 1, 0, 1); ov_val = 0;
    @(negedge clk); ovr0 = 0;
    chk("R5 differs from both lines", addr, 4'b0000);
  endtask

  task automatic t_restart;
    @(negedge clk); conn2 = 2'd0; ovr0 = 1; ov_val = 1;
    cyc(0, 1, 1, 0); ov_val = 0;
    cyc(1, 0, 0, 0); ov_val = 0;
    cyc(0, 1, 1, 0); ov_val = 0;
    cyc(1, 0, 0, 0); ov_val = 1;
    cyc(0, 0, 0, 0); ov_val = 0;
    cyc(1, 1, 0, 1); ov_val = 1;
    @(negedge clk); ovr0 = 0;
    chk("R9 history kept over repeated start", addr, 4'b0001);
  endtask

  task automatic t_all16;
    logic [3:0] prev;
    prev = addr;
    for (int c = 0; c < 16; c++) begin
      frame(c[3:2], c[1:0], prev);
      chk("R11 address combination", addr, c[3:0]);
      prev = c[3:0];
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_live_bus_tied();
        t_first_frame();
        t_fixed();
        t_stray_stop();
        t_both_diff();
        t_restart();
        t_all16();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule